// File: doc/BRIEF.md
# Shared-Line ADC Readout Controller

This block reads conversion results from a delta-sigma converter. The converter uses one line for two jobs: it signals that a result is ready and it shifts out the data bits. The controller synchronizes that line and waits for a falling level. It then requires the level to stay low for a programmable number of consecutive samples, so that a short glitch cannot start a transfer. It also refuses to start unless the line was seen high while the controller was idle. This keeps it from reading while the converter is updating its result.

Once ready is accepted, the controller waits a programmable settle time and then drives a serial clock whose half period is programmable in system-clock cycles. It captures 18 bits, most significant first, and then issues one extra clock pulse, which makes the converter drive the line high until its next result. The captured word is two's complement. The controller sign-extends it to 32 bits and presents it with a one-cycle strobe. If the line rises during the settle wait, the attempt is abandoned and a sticky error flag is raised.

Top module: `adc_line_reader`

## Requirements
- R1: The line passes through two synchronizer flops. A readout needs at least `cfg_qual` (≥1) consecutive low synchronized samples. A low pulse shorter than `cfg_qual` cycles starts no serial clock and leaves `err_flag` clear.
- R2: The first serial-clock rising edge comes exactly `cfg_qual + cfg_settle + 3` clock cycles after the first clock edge that sees `line_in` low (`cfg_settle` ≥ 2).
- R3: Each serial-clock pulse is high for exactly `cfg_half` cycles. Consecutive pulses are separated by exactly `cfg_half` low cycles (`cfg_half` ≥ 3).
- R4: Each readout produces exactly 19 serial-clock pulses: 18 data pulses and one extra pulse, and the extra pulse's bit is not captured.
- R5: Data bits are captured at the falling edges of the serial clock. The bit present after the first rising edge becomes result bit 17 (MSB), and the bit after the 18th rising edge becomes bit 0.
- R6: `rd_data[17:0]` holds the captured word, and `rd_data[31:18]` are copies of bit 17.
- R7: `rd_valid` is high for exactly one cycle. It rises in the same cycle in which the serial clock falls for the 19th time.
- R8: No readout starts unless the synchronized line was high while the controller was idle, after reset or after the previous readout. A line held low from reset, or held low after a readout, starts nothing.
- R9: If the line is seen high while the settle wait is running, no serial clock is issued and `err_flag` is set. A low of exactly `cfg_qual` cycles followed by high triggers this.
- R10: `err_flag` stays set until `err_clr` is asserted, and it reads 0 in the cycle after the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_half | input | 16 | Serial-clock half period, in clock cycles |
| cfg_settle | input | 24 | Wait between ready acceptance and the first serial clock, in cycles |
| cfg_qual | input | 8 | Consecutive low samples needed to accept ready |
| line_in | input | 1 | Shared ready/data line from the converter |
| err_clr | input | 1 | Clears the sticky error flag |
| sclk | output | 1 | Serial clock to the converter |
| rd_valid | output | 1 | One-cycle strobe for a new result |
| rd_data | output | 32 | Sign-extended result |
| err_flag | output | 1 | Sticky flag for ready withdrawn during the settle wait |

## Verification
A miscounted qualifier or settle counter shows up as a shifted first serial-clock edge, which is visible at the first pulse of a readout. A wrong half-period counter shows up as a pulse of the wrong width on the very next edge. A bit-counter error shows up as a 20th pulse, or as a missing one and a result shifted by one position, at the end of the same transfer. A lost arming state starts a transfer while the line is held low, within a few dozen cycles. Sweeping half period, qualification length and settle time over small values, with boundary data words and exactly-at-threshold glitches, brings each of these to the ports within one transfer.

// File: rtl/adc_line_pkg.sv
package adc_line_pkg;

    localparam int DATA_W = 18;
    localparam int OUT_W  = 32;
    localparam int PULSES = DATA_W + 1;
    localparam int CNT_W  = $clog2(PULSES + 1);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETTLE,
        ST_SHIFT,
        ST_DONE
    } rd_state_e;

    typedef struct packed {
        logic level;
        logic armed;
        logic qual_met;
    } line_view_t;

    function automatic logic [OUT_W-1:0] sign_extend(input logic [DATA_W-1:0] raw);
        return {{(OUT_W - DATA_W){raw[DATA_W-1]}}, raw};
    endfunction

endpackage

// File: rtl/adc_line_sync.sv
module adc_line_sync
    import adc_line_pkg::*;
#(
    parameter int STAGES = 2,
    parameter int QUAL_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              line_in,
    input  logic [QUAL_W-1:0] cfg_qual,
    input  logic              idle,
    input  logic              consume,
    output line_view_t        view
);

    logic [STAGES-1:0] sync_q;
    logic [QUAL_W-1:0] low_cnt;
    logic              armed_q;
    logic              level;

    // Reset to low so that reset alone never arms a readout.
    always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[STAGES-2:0], line_in};
    end

    assign level = sync_q[STAGES-1];

    always_ff @(posedge clk) begin
        if (rst)                low_cnt <= '0;
        else if (level)         low_cnt <= '0;
        else if (low_cnt < cfg_qual) low_cnt <= low_cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)                armed_q <= 1'b0;
        else if (consume)       armed_q <= 1'b0;
        else if (idle && level) armed_q <= 1'b1;
    end

    always_comb begin
        view.level    = level;
        view.armed    = armed_q;
        view.qual_met = (low_cnt >= cfg_qual);
    end

endmodule

// File: rtl/adc_line_pacer.sv
module adc_line_pacer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic [W-1:0] span,
    output logic         tick
);

    logic [W-1:0] cnt;

    assign tick = en && (cnt == span - W'(1));

    always_ff @(posedge clk) begin
        if (rst || !en) cnt <= '0;
        else if (tick)  cnt <= '0;
        else            cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/adc_line_ctrl.sv
module adc_line_ctrl
    import adc_line_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  line_view_t       view,
    input  logic             settle_tick,
    input  logic             half_tick,
    input  logic             err_clr,
    output logic             settle_en,
    output logic             half_en,
    output logic             consume,
    output logic             sclk,
    output logic             rd_valid,
    output logic [OUT_W-1:0] rd_data,
    output logic             err_flag,
    output rd_state_e        state
);

    rd_state_e          state_q, state_d;
    logic               sclk_q;
    logic [CNT_W-1:0]   pulses_q;
    logic [DATA_W-1:0]  shreg_q;
    logic [OUT_W-1:0]   result_q;
    logic               err_q;
    logic               abort;
    logic               fall;
    logic               last_fall;

    assign fall      = (state_q == ST_SHIFT) && half_tick && sclk_q;
    assign last_fall = fall && (pulses_q == CNT_W'(PULSES - 1));

    always_comb begin
        state_d = state_q;
        consume = 1'b0;
        abort   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (view.armed && view.qual_met) begin
                    consume = 1'b1;
                    state_d = ST_SETTLE;
                end
            end
            ST_SETTLE: begin
                if (view.level) begin
                    abort   = 1'b1;
                    state_d = ST_IDLE;
                end else if (settle_tick) begin
                    state_d = ST_SHIFT;
                end
            end
            ST_SHIFT: begin
                if (last_fall) state_d = ST_DONE;
            end
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst)                                 sclk_q <= 1'b0;
        else if (state_q == ST_SETTLE)           sclk_q <= settle_tick && !view.level;
        else if (state_q == ST_SHIFT && half_tick) sclk_q <= ~sclk_q;
        else if (state_q != ST_SHIFT)            sclk_q <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst || state_q == ST_SETTLE) pulses_q <= '0;
        else if (fall)                   pulses_q <= pulses_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)
            shreg_q <= '0;
        else if (fall && pulses_q < CNT_W'(DATA_W))
            shreg_q <= {shreg_q[DATA_W-2:0], view.level};
    end

    always_ff @(posedge clk) begin
        if (rst)            result_q <= '0;
        else if (last_fall) result_q <= sign_extend(shreg_q);
    end

    always_ff @(posedge clk) begin
        if (rst)          err_q <= 1'b0;
        else if (abort)   err_q <= 1'b1;
        else if (err_clr) err_q <= 1'b0;
    end

    assign settle_en = (state_q == ST_SETTLE);
    assign half_en   = (state_q == ST_SHIFT);
    assign sclk      = sclk_q;
    assign rd_valid  = (state_q == ST_DONE);
    assign rd_data   = result_q;
    assign err_flag  = err_q;
    assign state     = state_q;

endmodule

// File: rtl/adc_line_reader.sv
module adc_line_reader
    import adc_line_pkg::*;
#(
    parameter int HALF_W   = 16,
    parameter int SETTLE_W = 24,
    parameter int QUAL_W   = 8,
    parameter int STAGES   = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [HALF_W-1:0]   cfg_half,
    input  logic [SETTLE_W-1:0] cfg_settle,
    input  logic [QUAL_W-1:0]   cfg_qual,
    input  logic                line_in,
    input  logic                err_clr,
    output logic                sclk,
    output logic                rd_valid,
    output logic [OUT_W-1:0]    rd_data,
    output logic                err_flag
);

    line_view_t view_w;
    rd_state_e  state_w;
    logic       consume_w;
    logic       settle_en_w, settle_tick_w;
    logic       half_en_w, half_tick_w;

    adc_line_sync #(
        .STAGES (STAGES),
        .QUAL_W (QUAL_W)
    ) u_sync (
        .clk      (clk),
        .rst      (rst),
        .line_in  (line_in),
        .cfg_qual (cfg_qual),
        .idle     (state_w == ST_IDLE),
        .consume  (consume_w),
        .view     (view_w)
    );

    adc_line_pacer #(.W(SETTLE_W)) u_settle (
        .clk  (clk),
        .rst  (rst),
        .en   (settle_en_w),
        .span (cfg_settle),
        .tick (settle_tick_w)
    );

    adc_line_pacer #(.W(HALF_W)) u_half (
        .clk  (clk),
        .rst  (rst),
        .en   (half_en_w),
        .span (cfg_half),
        .tick (half_tick_w)
    );

    adc_line_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .view        (view_w),
        .settle_tick (settle_tick_w),
        .half_tick   (half_tick_w),
        .err_clr     (err_clr),
        .settle_en   (settle_en_w),
        .half_en     (half_en_w),
        .consume     (consume_w),
        .sclk        (sclk),
        .rd_valid    (rd_valid),
        .rd_data     (rd_data),
        .err_flag    (err_flag),
        .state       (state_w)
    );

endmodule

// File: rtl/adc_line_reader_chk.sv
module adc_line_reader_chk
    import adc_line_pkg::*;
(
    input logic                   clk,
    input logic                   rst,
    input logic                   sclk,
    input logic                   rd_valid,
    input logic [OUT_W-DATA_W:0]  sign_bits,
    input logic                   err_flag,
    input logic                   err_clr,
    input rd_state_e              state,
    input logic                   level,
    input logic                   armed
);

    // R7
    valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> !rd_valid);

    // R6
    sign_fill_chk: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> ($countones(sign_bits) == 0 || $countones(sign_bits) == OUT_W - DATA_W + 1));

    // R10
    err_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (err_flag && !err_clr) |=> err_flag);

    // R10
    err_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (err_clr && !(state == ST_SETTLE && level)) |=> !err_flag);

    // R9
    err_set_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SETTLE && level) |=> (err_flag && !sclk));

    // R8
    start_armed_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(state == ST_SETTLE) |-> $past(armed));

    // R4
    sclk_window_chk: assert property (@(posedge clk) disable iff (rst)
        sclk |-> (state == ST_SHIFT));

endmodule

bind adc_line_reader adc_line_reader_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .sclk      (sclk),
    .rd_valid  (rd_valid),
    .sign_bits (rd_data[adc_line_pkg::OUT_W-1:adc_line_pkg::DATA_W-1]),
    .err_flag  (err_flag),
    .err_clr   (err_clr),
    .state     (state_w),
    .level     (view_w.level),
    .armed     (view_w.armed)
);

// File: tb/adc_line_reader_bench.sv
module adc_line_reader_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] cfg_half;
    logic [23:0] cfg_settle;
    logic [7:0]  cfg_qual;
    logic        line_in;
    logic        err_clr;
    logic        sclk;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic        err_flag;

    int checks = 0;
    int errors = 0;
    int hh, qq, ss;

    always #5 clk = ~clk;

    adc_line_reader u_adc_line_reader (
        .clk        (clk),
        .rst        (rst),
        .cfg_half   (cfg_half),
        .cfg_settle (cfg_settle),
        .cfg_qual   (cfg_qual),
        .line_in    (line_in),
        .err_clr    (err_clr),
        .sclk       (sclk),
        .rd_valid   (rd_valid),
        .rd_data    (rd_data),
        .err_flag   (err_flag)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Observe for n cycles: no serial clock may appear.
    task automatic quiet(input int n, input string req);
        int seen = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (sclk) seen++;
        end
        chk(seen == 0, req, seen, 0);
    endtask

    // Converter model: one full readout of value v.
    task automatic read_word(input logic [17:0] v, input bit keep_low);
        int n = 0;
        int hi, lo, extra;
        logic [31:0] exp;
        @(negedge clk);
        line_in = 1'b0;
        do begin
            @(negedge clk);
            n++;
        end while (!sclk && n < 5000);
        // R2: start latency
        chk(n == qq + ss + 3, "R2", n, qq + ss + 3);
        for (int p = 0; p < 19; p++) begin
            line_in = (p < 18) ? v[17 - p] : !keep_low;
            hi = 0;
            while (sclk && hi < 5000) begin
                @(negedge clk);
                hi++;
            end
            // R3: high width
            chk(hi == hh, "R3", hi, hh);
            if (p == 18) begin
                exp = {{14{v[17]}}, v};
                // R7: strobe together with final fall
                chk(rd_valid == 1'b1, "R7", rd_valid, 1);
                // R5 / R6: bit order and sign extension
                chk(rd_data == exp, "R5_R6", rd_data, exp);
                @(negedge clk);
                chk(rd_valid == 1'b0, "R7", rd_valid, 0);
            end else begin
                chk(rd_valid == 1'b0, "R7", rd_valid, 0);
                lo = 0;
                while (!sclk && lo < 5000) begin
                    @(negedge clk);
                    lo++;
                end
                // R3: low gap
                chk(lo == hh, "R3", lo, hh);
            end
        end
        // R4: no 20th pulse
        extra = 0;
        for (int i = 0; i < 4 * hh; i++) begin
            @(negedge clk);
            if (sclk) extra++;
        end
        chk(extra == 0, "R4", extra, 0);
    endtask

    initial begin
        for (int i = 0; i < 200000; i++) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [17:0] vals [11];
        rst = 1'b1; line_in = 1'b0; err_clr = 1'b0;
        hh = 3; qq = 2; ss = 4;
        cfg_half = 16'(hh); cfg_qual = 8'(qq); cfg_settle = 24'(ss);
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(sclk == 0 && rd_valid == 0 && err_flag == 0 && rd_data == 0, "reset",
            {sclk, rd_valid, err_flag, rd_data}, 0);
        // R8: line low since reset never starts a readout
        quiet(80, "R8");
        chk(err_flag == 1'b0, "R8", err_flag, 0);
        line_in = 1'b1;
        repeat (5) @(negedge clk);

        vals[0] = 18'h00000; vals[1] = 18'h00001; vals[2] = 18'h1FFFF;
        vals[3] = 18'h20000; vals[4] = 18'h3FFFF; vals[5] = 18'h2AAAA;
        vals[6] = 18'h15555;
        for (int k = 7; k < 11; k++) vals[k] = 18'((k * 40503 + 977) & 18'h3FFFF);

        foreach (vals[k]) begin
            read_word(vals[k], 1'b0);
            repeat (3) @(negedge clk);
        end

        for (int h = 3; h <= 5; h += 2) begin
            for (int q = 1; q <= 3; q += 2) begin
                for (int s = 2; s <= 7; s += 5) begin
                    hh = h; qq = q; ss = s;
                    cfg_half = 16'(hh); cfg_qual = 8'(qq); cfg_settle = 24'(ss);
                    repeat (3) @(negedge clk);
                    foreach (vals[k]) begin
                        read_word(vals[k] ^ 18'(h * 7 + q * 3 + s), 1'b0);
                        repeat (2) @(negedge clk);
                    end
                    // R1: glitch one cycle shorter than qualification
                    if (qq > 1) begin
                        line_in = 1'b0;
                        repeat (qq - 1) @(negedge clk);
                        line_in = 1'b1;
                        quiet(ss + qq + 20, "R1");
                        chk(err_flag == 1'b0, "R1", err_flag, 0);
                    end
                    // R9: low of exactly the qualification length
                    line_in = 1'b0;
                    repeat (qq) @(negedge clk);
                    line_in = 1'b1;
                    quiet(ss + qq + 20, "R9");
                    chk(err_flag == 1'b1, "R9", err_flag, 1);
                    // R10: flag holds, then clears
                    repeat (10) @(negedge clk);
                    chk(err_flag == 1'b1, "R10", err_flag, 1);
                    err_clr = 1'b1;
                    @(negedge clk);
                    err_clr = 1'b0;
                    chk(err_flag == 1'b0, "R10", err_flag, 0);
                    // R8: line left low after a readout
                    read_word(18'h2C3A5, 1'b1);
                    quiet(ss + qq + 40, "R8");
                    line_in = 1'b1;
                    repeat (4) @(negedge clk);
                    read_word(18'h0F0F0, 1'b0);
                    repeat (3) @(negedge clk);
                end
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule